// File: doc/BRIEF.md
# E3 Serial Payload Transmit Interface

This block sits on the framer side of a serial link to terminal equipment. The framer owns the interface clock, and the equipment uses the same clock. The equipment shifts outbound payload into the framer one bit per clock. The block counts the bit slots of each 1536-slot frame and builds the outgoing serial frame. The first ten slots carry a fixed alignment pattern. Slot 10 carries the A bit and slot 11 carries the N bit. Slots 12 to 1535 carry payload taken from the equipment.

The block drives two pacing strobes to the equipment. The frame marker is high during the last slot of every frame. When the equipment sees it, the equipment starts the next frame's payload at once. The overhead strobe is high in the slot just before each overhead slot that the framer fills itself. The equipment then holds its next payload bit for one clock, and the framer ignores the serial input in that slot. A separate 2-bit select chooses the source of each of the A and N bits: the equipment's serial stream, or the framer itself.

A small state machine sets the slot kind. Its states are `SLOT_ALIGN`, `SLOT_ABIT`, `SLOT_NBIT` and `SLOT_PAYLOAD`. It moves through them as follows:
- align-done: `SLOT_ALIGN` to `SLOT_ABIT`, after the tenth alignment slot.
- a-done: `SLOT_ABIT` to `SLOT_NBIT`, always.
- n-done: `SLOT_NBIT` to `SLOT_PAYLOAD`, always.
- frame-wrap: `SLOT_PAYLOAD` to `SLOT_ALIGN`, on slot 1535.

Top module: `e3_ser_tx_if`

## Requirements
- R1: While `rst` is high at a clock edge, the slot position returns to alignment slot 0. `frame_mark`, `oh_strobe` and `line_out` are all 0 during reset. After `rst` falls, the first slot is slot 0.
- R2: A frame is 1536 slots long. `frame_mark` is high for exactly one clock, during slot 1535, and is low in every other slot.
- R3: Slots 0 to 9 carry the alignment word 1111010000, most significant bit in slot 0.
- R4: `oh_strobe` is high during slot p exactly when slot p+1 (mod 1536) is an overhead slot that the framer generates. That covers slots 0 to 9 always, slot 10 when the A bit is internal, and slot 11 when the N bit is internal. It is low in every other slot.
- R5: In payload slots 12 to 1535, the output bit is the `ser_in` value sampled at the rising edge that ends that slot.
- R6: `ser_in` has no effect on the output in any overhead slot that the framer generates.
- R7: `a_src_sel` equal to 2'b01 puts the sampled `ser_in` into slot 10. Any other code (00, 10, 11) puts `a_bit_val` there.
- R8: `n_src_sel` equal to 2'b01 puts the sampled `ser_in` into slot 11. Any other code puts a constant 1 there.
- R9: `line_out` is registered. During the clock that follows slot p, it shows the bit that belongs to slot p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface bit clock, sourced by the framer |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial payload from the terminal equipment |
| a_src_sel | input | 2 | A bit source: 01 = serial input, other codes = internal |
| n_src_sel | input | 2 | N bit source: 01 = serial input, other codes = internal 1 |
| a_bit_val | input | 1 | Internal value for the A bit |
| frame_mark | output | 1 | High during the last slot of each frame |
| oh_strobe | output | 1 | High one slot ahead of each framer-generated overhead slot |
| line_out | output | 1 | Assembled serial frame, one clock behind the slot |

## Verification
The frame marker and the overhead strobe are both high in slot 1535, because slot 0 of the next frame is alignment overhead. Running several whole frames makes this coincidence happen at every wrap. There, the bench requires both strobes high in the same cycle and the alignment bit one clock later. The A and N selects are changed only at frame starts, and slots with selects sourced from the equipment are mixed with internal ones. This shows the strobe being withheld before slot 10 or 11 while the frame marker timing stays the same. A reset in the middle of a frame checks the restart.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;
    typedef enum logic [1:0] {
        SLOT_ALIGN,
        SLOT_ABIT,
        SLOT_NBIT,
        SLOT_PAYLOAD
    } slot_e;

    localparam logic [1:0] SRC_EQUIP = 2'b01;
endpackage

// File: rtl/e3tx_slot_fsm.sv
module e3tx_slot_fsm
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int FAW_BITS   = 10,
    localparam int PW        = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    output slot_e         state_q,
    output slot_e         state_d,
    output logic [PW-1:0] pos_q,
    output logic          last_slot
);
    localparam logic [PW-1:0] LAST_POS  = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0] ALIGN_END = PW'(FAW_BITS - 1);

    logic [PW-1:0] pos_d;

    assign last_slot = (pos_q == LAST_POS);
    assign pos_d     = last_slot ? '0 : pos_q + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_ALIGN:   if (pos_q == ALIGN_END) state_d = SLOT_ABIT;
            SLOT_ABIT:    state_d = SLOT_NBIT;
            SLOT_NBIT:    state_d = SLOT_PAYLOAD;
            SLOT_PAYLOAD: if (last_slot) state_d = SLOT_ALIGN;
            default:      state_d = SLOT_ALIGN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_ALIGN;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // R2: the wrap lands on alignment slot 0
    assert_wrap_to_align_R2: assert property (@(posedge clk) disable iff (rst)
        last_slot |=> (pos_q == '0 && state_q == SLOT_ALIGN));
    // R3: alignment state covers only the first FAW_BITS slots
    assert_align_span_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_ALIGN) |-> (pos_q <= ALIGN_END));
endmodule

// File: rtl/e3tx_bit_merge.sv
module e3tx_bit_merge
    import e3tx_pkg::*;
#(
    parameter int                FAW_BITS = 10,
    parameter logic [FAW_BITS-1:0] FAW_WORD = 10'b1111010000,
    parameter int                PW       = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_e         slot,
    input  logic [PW-1:0] pos,
    input  logic          din,
    input  logic [1:0]    a_sel,
    input  logic [1:0]    n_sel,
    input  logic          a_val,
    output logic          line_q
);
    logic bit_d;
    logic faw_bit;

    always_comb begin
        faw_bit = 1'b0;
        for (int i = 0; i < FAW_BITS; i++) begin
            if (pos == PW'(i)) faw_bit = FAW_WORD[FAW_BITS-1-i];
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_ALIGN:   bit_d = faw_bit;
            SLOT_ABIT:    bit_d = (a_sel == SRC_EQUIP) ? din : a_val;
            SLOT_NBIT:    bit_d = (n_sel == SRC_EQUIP) ? din : 1'b1;
            SLOT_PAYLOAD: bit_d = din;
            default:      bit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= bit_d;
    end

    // R5 / R9: payload slots pass the sampled input one clock later
    assert_payload_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_PAYLOAD) |=> (line_q == $past(din)));
    // R8: an internal N bit is always 1
    assert_n_internal_R8: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_NBIT && n_sel != SRC_EQUIP) |=> line_q);
endmodule

// File: rtl/e3_ser_tx_if.sv
module e3_ser_tx_if
    import e3tx_pkg::*;
#(
    parameter int                  FRAME_BITS = 1536,
    parameter int                  FAW_BITS   = 10,
    parameter logic [FAW_BITS-1:0] FAW_WORD   = 10'b1111010000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_in,
    input  logic [1:0] a_src_sel,
    input  logic [1:0] n_src_sel,
    input  logic       a_bit_val,
    output logic       frame_mark,
    output logic       oh_strobe,
    output logic       line_out
);
    localparam int PW = $clog2(FRAME_BITS);

    slot_e         state_q;
    slot_e         state_d;
    logic [PW-1:0] pos_q;
    logic          last_slot;

    e3tx_slot_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .FAW_BITS   (FAW_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .state_q   (state_q),
        .state_d   (state_d),
        .pos_q     (pos_q),
        .last_slot (last_slot)
    );

    e3tx_bit_merge #(
        .FAW_BITS (FAW_BITS),
        .FAW_WORD (FAW_WORD),
        .PW       (PW)
    ) u_merge (
        .clk    (clk),
        .rst    (rst),
        .slot   (state_q),
        .pos    (pos_q),
        .din    (ser_in),
        .a_sel  (a_src_sel),
        .n_sel  (n_src_sel),
        .a_val  (a_bit_val),
        .line_q (line_out)
    );

    // Output process: strobes are decoded from the current slot and the look-ahead slot
    always_comb begin
        logic oh_next;
        unique case (state_d)
            SLOT_ALIGN:   oh_next = 1'b1;
            SLOT_ABIT:    oh_next = (a_src_sel != SRC_EQUIP);
            SLOT_NBIT:    oh_next = (n_src_sel != SRC_EQUIP);
            SLOT_PAYLOAD: oh_next = 1'b0;
            default:      oh_next = 1'b0;
        endcase
        oh_strobe  = !rst && oh_next;
        frame_mark = !rst && last_slot;
    end

    // R1: both strobes quiet while reset is applied
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> (!frame_mark && !oh_strobe));
    // R2: frame marker lasts a single clock
    assert_mark_single_R2: assert property (@(posedge clk) disable iff (rst)
        frame_mark |=> !frame_mark);
    // R4: a strobe is never followed by a payload slot
    assert_strobe_ahead_R4: assert property (@(posedge clk) disable iff (rst)
        oh_strobe |=> (state_q != SLOT_PAYLOAD));
    // R2 / R4: frame wrap raises both strobes together
    assert_wrap_both_R4: assert property (@(posedge clk) disable iff (rst)
        frame_mark |-> oh_strobe);
endmodule

// File: tb/e3_ser_tx_if_bench.sv
`timescale 1ns/1ps
module e3_ser_tx_if_bench;
    localparam int        FRAME = 1536;
    localparam logic [9:0] FAWC = 10'b1111010000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic [1:0] a_src_sel = 2'b00;
    logic [1:0] n_src_sel = 2'b00;
    logic       a_bit_val = 1'b0;
    logic       frame_mark, oh_strobe, line_out;

    int  n_checks = 0;
    int  n_errors = 0;
    int  bpos = 0;
    bit  prev_valid = 0;
    bit  prev_bit = 0;

    always #2.5 clk = ~clk;

    e3_ser_tx_if u_e3_ser_tx_if (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .a_src_sel  (a_src_sel),
        .n_src_sel  (n_src_sel),
        .a_bit_val  (a_bit_val),
        .frame_mark (frame_mark),
        .oh_strobe  (oh_strobe),
        .line_out   (line_out)
    );

    function automatic bit exp_bit(int p, bit din, logic [1:0] as, logic [1:0] ns, bit av);
        if (p < 10)  return FAWC[9-p];
        if (p == 10) return (as == 2'b01) ? din : av;
        if (p == 11) return (ns == 2'b01) ? din : 1'b1;
        return din;
    endfunction

    function automatic bit exp_oh(int pn, logic [1:0] as, logic [1:0] ns);
        if (pn < 10)  return 1'b1;
        if (pn == 10) return as != 2'b01;
        if (pn == 11) return ns != 2'b01;
        return 1'b0;
    endfunction

    task automatic chk(string req, logic act, logic exp, int p);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s slot=%0d actual=%b expected=%b", req, p, act, exp);
        end
    endtask

    task automatic reset_checks(int cycles);
        rst = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk); #1;
            chk("R1 frame_mark", frame_mark, 1'b0, -1);
            chk("R1 oh_strobe", oh_strobe, 1'b0, -1);
            if (k > 0) chk("R1 line_out", line_out, 1'b0, -1);
        end
        @(negedge clk);
        rst = 1'b0;
        bpos = 0;
        prev_valid = 0;
    endtask

    // One slot: check outputs of this slot, then drive the slot's input
    task automatic run_slots(int count, int mode);
        for (int k = 0; k < count; k++) begin
            bit din;
            bit internal_oh;
            #1;
            chk("R2 frame_mark", frame_mark, bpos == FRAME - 1, bpos);
            chk("R4 oh_strobe", oh_strobe, exp_oh((bpos + 1) % FRAME, a_src_sel, n_src_sel), bpos);
            if (prev_valid) begin
                if (bpos == 0)                chk("R9 line_out wrap", line_out, prev_bit, bpos);
                else if (bpos - 1 < 10)       chk("R3 align bit", line_out, prev_bit, bpos - 1);
                else if (bpos - 1 == 10)      chk("R7 A bit", line_out, prev_bit, bpos - 1);
                else if (bpos - 1 == 11)      chk("R8 N bit", line_out, prev_bit, bpos - 1);
                else                          chk("R5 payload", line_out, prev_bit, bpos - 1);
            end
            internal_oh = (bpos < 10) || (bpos == 10 && a_src_sel != 2'b01)
                       || (bpos == 11 && n_src_sel != 2'b01);
            // R6: in framer-owned slots drive the inverse of the slot's value
            if (internal_oh && mode == 1)
                din = !exp_bit(bpos, 1'b0, a_src_sel, n_src_sel, a_bit_val);
            else
                din = 1'($urandom());
            ser_in = din;
            prev_bit = exp_bit(bpos, din, a_src_sel, n_src_sel, a_bit_val);
            prev_valid = 1;
            bpos = (bpos + 1) % FRAME;
            @(negedge clk);
        end
    endtask

    task automatic run_frame(logic [1:0] as, logic [1:0] ns, bit av, int mode);
        a_src_sel = as;
        n_src_sel = ns;
        a_bit_val = av;
        run_slots(FRAME, mode);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        reset_checks(4);
        run_frame(2'b00, 2'b00, 1'b0, 1);   // R7 R8 internal, R6 opposing input
        run_frame(2'b01, 2'b01, 1'b0, 0);   // R7 R8 from equipment
        run_frame(2'b10, 2'b11, 1'b1, 1);   // other internal codes, A=1
        run_frame(2'b01, 2'b00, 1'b1, 0);   // mixed sources
        a_src_sel = 2'b11;
        n_src_sel = 2'b01;
        run_slots(517, 1);
        reset_checks(3);                    // R1 mid-frame reset
        run_frame(2'b00, 2'b01, 1'b1, 1);
        run_slots(20, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog slot=%0d actual=running expected=done", bpos);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule